// File: doc/BRIEF.md
# USB Host Controller Register Bank

This block is the software-visible register bank of a simple full-speed USB host controller. It decodes byte, word and longword accesses that fall in a 32-byte I/O window. It holds six registers: command, status, interrupt enable, frame number, frame list base and start-of-frame timing. It also keeps a hidden two-bit cause register. This register tells a transfer-completion interrupt apart from a short-packet interrupt, although both share one status bit.

The frame engine reports events through a six-bit sideband vector. These events set the cause and status bits. Software clears status bits by writing ones. The block drives a registered, level-sensitive interrupt line, the run level, a one-cycle start pulse, and separate one-cycle host-reset and bus-reset pulses. The upper half of the window belongs to a separate port-status block. For a word access there, this block raises a select strobe with a port index and returns that block's read data.

Top module: `hcr_regbank`

## Requirements
- R1: Only address bits 4:0 are decoded. Command is at 0x00 (word), status at 0x02 (word), interrupt enable at 0x04 (word), frame number at 0x06 (word), frame list base at 0x08 (longword) and start-of-frame timing at 0x0C (byte). Higher address bits alias. Size codes on acc_size are 0 byte, 1 word, 2 longword.
- R2: After rst_n, every register reads zero except start-of-frame timing, which reads 64. irq_o, run_o and all pulses are low.
- R3: A command write with bits 1 and 2 clear stores all 16 bits, and run_o follows command bit 0. If bit 0 goes from clear to set, start_o pulses for one cycle and status bit 5 (halted) clears. A write with bit 0 clear sets the halted bit.
- R4: A command write with bit 1 or bit 2 set is not stored. Instead, command, status, cause, interrupt enable and frame list base go to zero and start-of-frame timing goes to 64. The frame number is kept, and the reset wins over same-cycle sideband events. bus_rst_o pulses when bit 2 is set; otherwise hc_rst_o pulses.
- R5: Status bits are write-one-to-clear: 0 interrupt, 1 bus error, 2 resume detect, 3 host system error, 4 process error, 5 halted. A sideband set and a clear in the same cycle leave the bit set.
- R6: Sideband bit 0 (completion) sets cause bit 0, and sideband bit 1 (short packet) sets cause bit 1. Either one also sets status bit 0. Writing 1 to status bit 0 clears both cause bits.
- R7: irq_o is high when any of these holds: cause bit 0 with enable bit 2, cause bit 1 with enable bit 3, status bit 1 with enable bit 0, status bit 2 with enable bit 1, or status bit 3 or 4 alone. It reflects the state after the same clock edge as the write or event that changed it. Sideband bits 2 to 5 set status bits 1 to 4.
- R8: A frame number write takes effect only while the halted bit is set, and keeps bits 10:0.
- R9: A frame list base write stores the longword with bits 11:0 forced to zero.
- R10: A byte write at 0x0C stores start-of-frame timing.
- R11: An access whose size does not match a mapped register is unmapped; a write there has no effect. Unmapped reads return 0xFF for a byte, 0xFF7F for a word and 0xFFFFFFFF for a longword or for size code 3. The narrower values are zero-extended, and acc_rdata is zero when no read is under way.
- R12: A word access with address bit 4 set uses port index bits 3:1. If the index is below NUM_PORTS, port_sel_o is raised, port_idx_o carries the index and a read returns port_rdata_i. Otherwise the read returns 0xFF7F and port_sel_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_en | input | 1 | Access valid this cycle |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | 0 byte, 1 word, 2 longword |
| acc_addr | input | ADDR_W | Access address |
| acc_wdata | input | 32 | Write data |
| acc_rdata | output | 32 | Read data, zero-extended |
| evt_set | input | 6 | Frame engine event sets |
| port_rdata_i | input | 16 | Read data from the port block |
| port_sel_o | output | 1 | Port block select strobe |
| port_idx_o | output | 3 | Selected port index |
| irq_o | output | 1 | Level interrupt |
| run_o | output | 1 | Run level (command bit 0) |
| start_o | output | 1 | Start pulse |
| hc_rst_o | output | 1 | Host-reset pulse |
| bus_rst_o | output | 1 | Bus-reset pulse |
| frame_num_o | output | FRN_W | Frame number |
| frame_base_o | output | 32 | Frame list base |
| sof_o | output | 8 | Start-of-frame timing |

## Verification
Every offset of the window is read with every size code from the reset state. This separates the mapped registers from the three unmapped fill values and from the port window with valid and invalid indices.

The interrupt sweep crosses each of 16 enable patterns with each single sideband event. This shows which enable gates which cause, and that the two error causes ignore the enables.

Targeted sequences cover the remaining cases:
- frame number writes made before and after the first halt;
- a repeated run write that must not restart;
- a clear colliding with a set;
- soft resets colliding with events;
- wrong-size writes that must leave the state alone.

// File: rtl/hcr_pkg.sv
package hcr_pkg;

   typedef enum logic [1:0] {
      SZ_BYTE = 2'd0,
      SZ_WORD = 2'd1,
      SZ_LONG = 2'd2,
      SZ_NONE = 2'd3
   } acc_size_e;

   typedef enum logic [3:0] {
      RS_FILL_B,
      RS_FILL_W,
      RS_FILL_L,
      RS_CMD,
      RS_STS,
      RS_IEN,
      RS_FRN,
      RS_FLB,
      RS_SOF,
      RS_PORT
   } rd_src_e;

   localparam logic [4:0] OFS_CMD = 5'h00;
   localparam logic [4:0] OFS_STS = 5'h02;
   localparam logic [4:0] OFS_IEN = 5'h04;
   localparam logic [4:0] OFS_FRN = 5'h06;
   localparam logic [4:0] OFS_FLB = 5'h08;
   localparam logic [4:0] OFS_SOF = 5'h0C;

   localparam int STS_W   = 6;
   localparam int STB_INT = 0;
   localparam int STB_ERR = 1;
   localparam int STB_RES = 2;
   localparam int STB_HSE = 3;
   localparam int STB_PRE = 4;
   localparam int STB_HLT = 5;

   localparam int EV_W     = 6;
   localparam int EV_DONE  = 0;
   localparam int EV_SHORT = 1;
   localparam int EV_ERR   = 2;
   localparam int EV_RES   = 3;
   localparam int EV_HSE   = 4;
   localparam int EV_PRE   = 5;

   localparam int CMD_W = 16;

   typedef struct packed {
      logic cmd;
      logic sts;
      logic ien;
      logic frn;
      logic flb;
      logic sof;
   } wr_strb_t;

   function automatic logic irq_eval(input logic [STS_W-1:0] sts,
                                     input logic [1:0]       cause,
                                     input logic [CMD_W-1:0] ien);
      return (cause[0] & ien[2]) | (cause[1] & ien[3]) |
             (sts[STB_ERR] & ien[0]) | (sts[STB_RES] & ien[1]) |
             sts[STB_HSE] | sts[STB_PRE];
   endfunction

endpackage

// File: rtl/hcr_decode.sv
module hcr_decode
   import hcr_pkg::*;
#(
   parameter int ADDR_W    = 16,
   parameter int NUM_PORTS = 2
) (
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [1:0]        acc_size,
   input  logic [ADDR_W-1:0] acc_addr,
   output wr_strb_t          wstrb,
   output rd_src_e           rsel,
   output logic              rd_act,
   output logic              port_sel_o,
   output logic [2:0]        port_idx_o
);

   localparam logic [2:0] PORT_LIM = 3'(NUM_PORTS);

   logic [4:0]  ofs;
   logic [2:0]  pidx;
   logic        idx_ok;
   logic        port_hit;
   logic        wr_act;
   acc_size_e   sz;
   logic        unused_addr;

   assign ofs         = acc_addr[4:0];
   assign pidx        = ofs[3:1];
   assign sz          = acc_size_e'(acc_size);
   assign unused_addr = ^acc_addr;

   generate
      if (NUM_PORTS >= 8) begin : g_all_ports
         assign idx_ok = 1'b1;
      end else begin : g_some_ports
         assign idx_ok = (pidx < PORT_LIM);
      end
   endgenerate

   assign port_hit = ofs[4] && idx_ok && (sz == SZ_WORD);

   always_comb begin
      rsel = RS_FILL_L;
      unique case (sz)
         SZ_BYTE: rsel = (ofs == OFS_SOF) ? RS_SOF : RS_FILL_B;
         SZ_WORD: begin
            if (port_hit)            rsel = RS_PORT;
            else if (ofs == OFS_CMD) rsel = RS_CMD;
            else if (ofs == OFS_STS) rsel = RS_STS;
            else if (ofs == OFS_IEN) rsel = RS_IEN;
            else if (ofs == OFS_FRN) rsel = RS_FRN;
            else                     rsel = RS_FILL_W;
         end
         SZ_LONG: rsel = (ofs == OFS_FLB) ? RS_FLB : RS_FILL_L;
         default: rsel = RS_FILL_L;
      endcase
   end

   assign wr_act    = acc_en && acc_wr;
   assign rd_act    = acc_en && !acc_wr;
   assign wstrb.cmd = wr_act && (rsel == RS_CMD);
   assign wstrb.sts = wr_act && (rsel == RS_STS);
   assign wstrb.ien = wr_act && (rsel == RS_IEN);
   assign wstrb.frn = wr_act && (rsel == RS_FRN);
   assign wstrb.flb = wr_act && (rsel == RS_FLB);
   assign wstrb.sof = wr_act && (rsel == RS_SOF);

   assign port_sel_o = acc_en && port_hit;
   assign port_idx_o = pidx;

   always_comb begin
      if (port_sel_o) begin
         AST_PORT_WINDOW: assert (acc_addr[4] && acc_size == 2'd1); // R12
      end
      AST_ONE_STROBE: assert ($onehot0(wstrb)); // R1
   end

endmodule

// File: rtl/hcr_ctrl.sv
module hcr_ctrl
   import hcr_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_w,
   input  logic             sts_w,
   input  logic             ien_w,
   input  logic [CMD_W-1:0] wdata,
   input  logic [EV_W-1:0]  evt_set,
   output logic             soft_rst,
   output logic [CMD_W-1:0] cmd_q,
   output logic [STS_W-1:0] sts_q,
   output logic [CMD_W-1:0] ien_q,
   output logic             irq_o,
   output logic             start_o,
   output logic             hc_rst_o,
   output logic             bus_rst_o
);

   logic [CMD_W-1:0] cmd_n;
   logic [STS_W-1:0] sts_n;
   logic [CMD_W-1:0] ien_n;
   logic [1:0]       cause_q;
   logic [1:0]       cause_n;
   logic             start_n;

   assign soft_rst = cmd_w && (wdata[1] || wdata[2]);

   always_comb begin
      cmd_n   = cmd_q;
      sts_n   = sts_q;
      ien_n   = ien_q;
      cause_n = cause_q;
      start_n = 1'b0;

      if (cmd_w) begin
         if (wdata[0] && !cmd_q[0]) begin
            start_n        = 1'b1;
            sts_n[STB_HLT] = 1'b0;
         end else if (!wdata[0]) begin
            sts_n[STB_HLT] = 1'b1;
         end
         cmd_n = wdata;
      end

      if (sts_w) begin
         sts_n = sts_n & ~wdata[STS_W-1:0];
         if (wdata[STB_INT]) cause_n = 2'b00;
      end

      if (ien_w) ien_n = wdata;

      cause_n[0]     = cause_n[0] | evt_set[EV_DONE];
      cause_n[1]     = cause_n[1] | evt_set[EV_SHORT];
      sts_n[STB_INT] = sts_n[STB_INT] | evt_set[EV_DONE] | evt_set[EV_SHORT];
      sts_n[STB_ERR] = sts_n[STB_ERR] | evt_set[EV_ERR];
      sts_n[STB_RES] = sts_n[STB_RES] | evt_set[EV_RES];
      sts_n[STB_HSE] = sts_n[STB_HSE] | evt_set[EV_HSE];
      sts_n[STB_PRE] = sts_n[STB_PRE] | evt_set[EV_PRE];

      if (soft_rst) begin
         cmd_n   = '0;
         sts_n   = '0;
         ien_n   = '0;
         cause_n = '0;
         start_n = 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q     <= '0;
         sts_q     <= '0;
         ien_q     <= '0;
         cause_q   <= '0;
         irq_o     <= 1'b0;
         start_o   <= 1'b0;
         hc_rst_o  <= 1'b0;
         bus_rst_o <= 1'b0;
      end else begin
         cmd_q     <= cmd_n;
         sts_q     <= sts_n;
         ien_q     <= ien_n;
         cause_q   <= cause_n;
         irq_o     <= irq_eval(sts_n, cause_n, ien_n);
         start_o   <= start_n;
         hc_rst_o  <= soft_rst && !wdata[2];
         bus_rst_o <= cmd_w && wdata[2];
      end
   end

   AST_IRQ_TRACKS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o == irq_eval(sts_q, cause_q, ien_q)); // R7

   AST_SOFT_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (cmd_q == '0 && sts_q == '0 && ien_q == '0 && cause_q == 2'b00)); // R4

   AST_RESET_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hc_rst_o, bus_rst_o})); // R4

   AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_set[EV_HSE] && !soft_rst) |=> sts_q[STB_HSE]); // R5

   AST_CAUSE_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
      (sts_w && wdata[STB_INT] && !evt_set[EV_DONE] && !evt_set[EV_SHORT])
      |=> cause_q == 2'b00); // R6

   AST_START_UNHALTS: assert property (@(posedge clk) disable iff (!rst_n)
      start_o |-> (!sts_q[STB_HLT] && cmd_q[0])); // R3

   AST_STOP_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_w && !wdata[0] && !soft_rst) |=> sts_q[STB_HLT]); // R3

endmodule

// File: rtl/hcr_frame_regs.sv
module hcr_frame_regs #(
   parameter int          FRN_W     = 11,
   parameter int          FLB_ALIGN = 12,
   parameter logic [7:0]  SOF_RST   = 8'd64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             frn_w,
   input  logic             flb_w,
   input  logic             sof_w,
   input  logic             soft_rst,
   input  logic             halted,
   input  logic [31:0]      wdata,
   output logic [FRN_W-1:0] frn_q,
   output logic [31:0]      flb_q,
   output logic [7:0]       sof_q
);

   localparam logic [31:0] FLB_MASK = ~((32'd1 << FLB_ALIGN) - 32'd1);

   logic [31:0] flb_in;

   generate
      if (FLB_ALIGN == 0) begin : g_no_align
         assign flb_in = wdata;
      end else begin : g_align
         assign flb_in = wdata & FLB_MASK;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frn_q <= '0;
      end else if (frn_w && halted) begin
         frn_q <= wdata[FRN_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flb_q <= '0;
         sof_q <= SOF_RST;
      end else if (soft_rst) begin
         flb_q <= '0;
         sof_q <= SOF_RST;
      end else begin
         if (flb_w) flb_q <= flb_in;
         if (sof_w) sof_q <= wdata[7:0];
      end
   end

   AST_FRAME_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !(frn_w && halted) |=> $stable(frn_q)); // R8

   AST_SOF_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
      soft_rst |=> (sof_q == SOF_RST && flb_q == '0)); // R4

   AST_BASE_SETTLES: assert property (@(posedge clk) disable iff (!rst_n)
      (flb_w && !soft_rst) |=> flb_q[31:FLB_ALIGN] == $past(wdata[31:FLB_ALIGN])); // R9

endmodule

// File: rtl/hcr_rdmux.sv
module hcr_rdmux
   import hcr_pkg::*;
#(
   parameter int FRN_W = 11
) (
   input  rd_src_e          rsel,
   input  logic             rd_act,
   input  logic [CMD_W-1:0] cmd_q,
   input  logic [STS_W-1:0] sts_q,
   input  logic [CMD_W-1:0] ien_q,
   input  logic [FRN_W-1:0] frn_q,
   input  logic [31:0]      flb_q,
   input  logic [7:0]       sof_q,
   input  logic [15:0]      port_rdata_i,
   output logic [31:0]      acc_rdata
);

   logic [31:0] val;

   always_comb begin
      unique case (rsel)
         RS_FILL_B: val = 32'h0000_00FF;
         RS_FILL_W: val = 32'h0000_FF7F;
         RS_CMD:    val = 32'(cmd_q);
         RS_STS:    val = 32'(sts_q);
         RS_IEN:    val = 32'(ien_q);
         RS_FRN:    val = 32'(frn_q);
         RS_FLB:    val = flb_q;
         RS_SOF:    val = 32'(sof_q);
         RS_PORT:   val = 32'(port_rdata_i);
         default:   val = 32'hFFFF_FFFF;
      endcase
   end

   assign acc_rdata = rd_act ? val : 32'h0;

endmodule

// File: rtl/hcr_regbank.sv
module hcr_regbank
   import hcr_pkg::*;
#(
   parameter int         ADDR_W    = 16,
   parameter int         NUM_PORTS = 2,
   parameter int         FRN_W     = 11,
   parameter int         FLB_ALIGN = 12,
   parameter logic [7:0] SOF_RST   = 8'd64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              acc_en,
   input  logic              acc_wr,
   input  logic [1:0]        acc_size,
   input  logic [ADDR_W-1:0] acc_addr,
   input  logic [31:0]       acc_wdata,
   output logic [31:0]       acc_rdata,
   input  logic [5:0]        evt_set,
   input  logic [15:0]       port_rdata_i,
   output logic              port_sel_o,
   output logic [2:0]        port_idx_o,
   output logic              irq_o,
   output logic              run_o,
   output logic              start_o,
   output logic              hc_rst_o,
   output logic              bus_rst_o,
   output logic [FRN_W-1:0]  frame_num_o,
   output logic [31:0]       frame_base_o,
   output logic [7:0]        sof_o
);

   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must span the 32-byte window");
      end
      if (NUM_PORTS < 1 || NUM_PORTS > 8) begin : g_bad_ports
         $error("NUM_PORTS must be within 1..8");
      end
      if (FRN_W < 1 || FRN_W > 16) begin : g_bad_frn
         $error("FRN_W must be within 1..16");
      end
      if (FLB_ALIGN < 0 || FLB_ALIGN > 31) begin : g_bad_align
         $error("FLB_ALIGN must be within 0..31");
      end
   endgenerate

   wr_strb_t         wstrb;
   rd_src_e          rsel;
   logic             rd_act;
   logic             soft_rst;
   logic [CMD_W-1:0] cmd_q;
   logic [STS_W-1:0] sts_q;
   logic [CMD_W-1:0] ien_q;

   hcr_decode #(
      .ADDR_W    (ADDR_W),
      .NUM_PORTS (NUM_PORTS)
   ) u_decode (
      .acc_en     (acc_en),
      .acc_wr     (acc_wr),
      .acc_size   (acc_size),
      .acc_addr   (acc_addr),
      .wstrb      (wstrb),
      .rsel       (rsel),
      .rd_act     (rd_act),
      .port_sel_o (port_sel_o),
      .port_idx_o (port_idx_o)
   );

   hcr_ctrl u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .cmd_w     (wstrb.cmd),
      .sts_w     (wstrb.sts),
      .ien_w     (wstrb.ien),
      .wdata     (acc_wdata[CMD_W-1:0]),
      .evt_set   (evt_set),
      .soft_rst  (soft_rst),
      .cmd_q     (cmd_q),
      .sts_q     (sts_q),
      .ien_q     (ien_q),
      .irq_o     (irq_o),
      .start_o   (start_o),
      .hc_rst_o  (hc_rst_o),
      .bus_rst_o (bus_rst_o)
   );

   hcr_frame_regs #(
      .FRN_W     (FRN_W),
      .FLB_ALIGN (FLB_ALIGN),
      .SOF_RST   (SOF_RST)
   ) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .frn_w    (wstrb.frn),
      .flb_w    (wstrb.flb),
      .sof_w    (wstrb.sof),
      .soft_rst (soft_rst),
      .halted   (sts_q[STB_HLT]),
      .wdata    (acc_wdata),
      .frn_q    (frame_num_o),
      .flb_q    (frame_base_o),
      .sof_q    (sof_o)
   );

   hcr_rdmux #(
      .FRN_W (FRN_W)
   ) u_rdmux (
      .rsel         (rsel),
      .rd_act       (rd_act),
      .cmd_q        (cmd_q),
      .sts_q        (sts_q),
      .ien_q        (ien_q),
      .frn_q        (frame_num_o),
      .flb_q        (frame_base_o),
      .sof_q        (sof_o),
      .port_rdata_i (port_rdata_i),
      .acc_rdata    (acc_rdata)
   );

   assign run_o = cmd_q[0];

   AST_RUN_FOLLOWS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (wstrb.cmd && !soft_rst) |=> run_o == $past(acc_wdata[0])); // R3

endmodule

// File: tb/hcr_regbank_test.sv
`timescale 1ns/1ps
module hcr_regbank_test;

   localparam int NPORT = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        acc_en = 1'b0;
   logic        acc_wr = 1'b0;
   logic [1:0]  acc_size = 2'd0;
   logic [15:0] acc_addr = 16'h0;
   logic [31:0] acc_wdata = 32'h0;
   logic [31:0] acc_rdata;
   logic [5:0]  evt_set = 6'h0;
   logic [15:0] port_rdata_i = 16'hA5C3;
   logic        port_sel_o;
   logic [2:0]  port_idx_o;
   logic        irq_o, run_o, start_o, hc_rst_o, bus_rst_o;
   logic [10:0] frame_num_o;
   logic [31:0] frame_base_o;
   logic [7:0]  sof_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   logic [15:0] m_cmd, m_ien;
   logic [5:0]  m_sts;
   logic [1:0]  m_hid;
   logic [10:0] m_frn;
   logic [31:0] m_flb;
   logic [7:0]  m_sof;
   logic        m_start;

   always #5 clk = ~clk;

   hcr_regbank #(.NUM_PORTS(NPORT)) uut (
      .clk(clk), .rst_n(rst_n), .acc_en(acc_en), .acc_wr(acc_wr),
      .acc_size(acc_size), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
      .acc_rdata(acc_rdata), .evt_set(evt_set), .port_rdata_i(port_rdata_i),
      .port_sel_o(port_sel_o), .port_idx_o(port_idx_o), .irq_o(irq_o),
      .run_o(run_o), .start_o(start_o), .hc_rst_o(hc_rst_o),
      .bus_rst_o(bus_rst_o), .frame_num_o(frame_num_o),
      .frame_base_o(frame_base_o), .sof_o(sof_o)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic m_soft();
      m_cmd = 0; m_sts = 0; m_hid = 0; m_ien = 0; m_flb = 0; m_sof = 8'd64;
   endtask

   function automatic logic exp_irq();
      return (m_hid[0] & m_ien[2]) | (m_hid[1] & m_ien[3]) |
             (m_sts[1] & m_ien[0]) | (m_sts[2] & m_ien[1]) | m_sts[3] | m_sts[4];
   endfunction

   function automatic logic [31:0] exp_rd(input logic [1:0] sz, input logic [4:0] o);
      case (sz)
         2'd0: return (o == 5'h0C) ? {24'h0, m_sof} : 32'hFF;
         2'd1: begin
            if (o[4]) return (int'(o[3:1]) < NPORT) ? {16'h0, port_rdata_i} : 32'hFF7F;
            case (o)
               5'h00: return {16'h0, m_cmd};
               5'h02: return {26'h0, m_sts};
               5'h04: return {16'h0, m_ien};
               5'h06: return {21'h0, m_frn};
               default: return 32'hFF7F;
            endcase
         end
         2'd2: return (o == 5'h08) ? m_flb : 32'hFFFF_FFFF;
         default: return 32'hFFFF_FFFF;
      endcase
   endfunction

   // model update for one write, from the requirement text
   task automatic m_write(input logic [1:0] sz, input logic [4:0] o, input logic [31:0] d);
      m_start = 1'b0;
      if (sz == 2'd0 && o == 5'h0C) m_sof = d[7:0];
      if (sz == 2'd2 && o == 5'h08) m_flb = {d[31:12], 12'h0};
      if (sz == 2'd1) begin
         case (o)
            5'h00: begin
               if (d[1] || d[2]) m_soft();
               else begin
                  if (d[0] && !m_cmd[0]) begin m_start = 1'b1; m_sts[5] = 1'b0; end
                  else if (!d[0]) m_sts[5] = 1'b1;
                  m_cmd = d[15:0];
               end
            end
            5'h02: begin m_sts = m_sts & ~d[5:0]; if (d[0]) m_hid = 0; end
            5'h04: m_ien = d[15:0];
            5'h06: if (m_sts[5]) m_frn = d[10:0];
            default: ;
         endcase
      end
   endtask

   task automatic m_event(input logic [5:0] e);
      m_hid = m_hid | e[1:0];
      m_sts[0] = m_sts[0] | e[0] | e[1];
      m_sts[4:1] = m_sts[4:1] | e[5:2];
   endtask

   task automatic do_wr(input logic [1:0] sz, input logic [15:0] a, input logic [31:0] d,
                        input logic [5:0] e);
      @(negedge clk);
      acc_en = 1; acc_wr = 1; acc_size = sz; acc_addr = a; acc_wdata = d; evt_set = e;
      @(negedge clk);
      acc_en = 0; acc_wr = 0; evt_set = 0;
      m_write(sz, a[4:0], d);
      if (!((sz == 2'd1) && (a[4:0] == 5'h00) && (d[1] || d[2]))) m_event(e);
   endtask

   task automatic do_evt(input logic [5:0] e);
      @(negedge clk);
      evt_set = e;
      @(negedge clk);
      evt_set = 0;
      m_event(e);
   endtask

   task automatic do_rd(input logic [1:0] sz, input logic [15:0] a,
                        output logic [31:0] v, output logic sel, output logic [2:0] idx);
      @(negedge clk);
      acc_en = 1; acc_wr = 0; acc_size = sz; acc_addr = a;
      #1;
      v = acc_rdata; sel = port_sel_o; idx = port_idx_o;
      acc_en = 0;
   endtask

   task automatic chk_reg(input string tag, input logic [1:0] sz, input logic [4:0] o);
      logic [31:0] v; logic s; logic [2:0] i;
      do_rd(sz, {11'h0, o}, v, s, i);
      chk(tag, v, exp_rd(sz, o));
   endtask

   initial begin
      logic [31:0] v; logic s; logic [2:0] i;
      m_cmd = 0; m_sts = 0; m_hid = 0; m_ien = 0; m_frn = 0; m_flb = 0; m_sof = 64;
      m_start = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;

      // R2 reset state
      @(negedge clk);
      chk("R2 irq", {31'h0, irq_o}, 0);
      chk("R2 run", {31'h0, run_o}, 0);
      chk("R2 pulses", {29'h0, start_o, hc_rst_o, bus_rst_o}, 0);
      chk("R2 sof", {24'h0, sof_o}, 32'd64);
      chk("R11 idle rdata", acc_rdata, 0);

      // R1 R11 R12 full sweep of offsets and sizes from reset state
      for (int sz = 0; sz < 4; sz++) begin
         for (int o = 0; o < 32; o++) begin
            logic exp_sel;
            do_rd(2'(sz), 16'(o), v, s, i);
            chk("R11 R1 sweep read", v, exp_rd(2'(sz), 5'(o)));
            exp_sel = (sz == 1) && (o >= 16) && (((o >> 1) & 7) < NPORT);
            chk("R12 port select", {31'h0, s}, {31'h0, exp_sel});
            if (exp_sel) chk("R12 port index", {29'h0, i}, 32'((o >> 1) & 7));
         end
      end

      // R1 aliasing through high address bits
      do_wr(2'd0, 16'hBEEC, 32'h5A, 0);
      chk("R1 alias write", {24'h0, sof_o}, 32'h5A);
      do_rd(2'd0, 16'h702C, v, s, i);
      chk("R1 alias read", v, 32'h5A);

      // R11 wrong-size writes ignored
      do_wr(2'd0, 16'h0000, 32'h01, 0);
      chk("R11 byte cmd", {31'h0, run_o}, 0);
      chk_reg("R11 cmd unchanged", 2'd1, 5'h00);
      do_wr(2'd2, 16'h000C, 32'h11, 0);
      chk("R11 long sof", {24'h0, sof_o}, 32'h5A);
      do_wr(2'd1, 16'h0008, 32'hF000, 0);
      chk("R11 word base", frame_base_o, 0);
      do_wr(2'd3, 16'h0004, 32'hFFFF, 0);
      chk_reg("R11 size3 enable", 2'd1, 5'h04);

      // R8 frame number ignored before halt
      do_wr(2'd1, 16'h0006, 32'h0123, 0);
      chk("R8 not halted", {21'h0, frame_num_o}, 0);
      // R3 stop sets halted
      do_wr(2'd1, 16'h0000, 32'h0040, 0);
      chk_reg("R3 halted", 2'd1, 5'h02);
      for (int k = 0; k < 8; k++) begin
         logic [31:0] d = 32'(k * 16'h2D95 + 16'h0F0F);
         do_wr(2'd1, 16'h0006, d, 0);
         chk("R8 halted write", {21'h0, frame_num_o}, {21'h0, d[10:0]});
      end

      // R3 run
      do_wr(2'd1, 16'h0000, 32'h0081, 0);
      chk("R3 start pulse", {31'h0, start_o}, 1);
      chk("R3 run", {31'h0, run_o}, 1);
      chk_reg("R3 halt cleared", 2'd1, 5'h02);
      chk_reg("R3 cmd stored", 2'd1, 5'h00);
      chk("R3 start one cycle", {31'h0, start_o}, 0);
      do_wr(2'd1, 16'h0006, 32'h0555, 0);
      chk("R8 running ignored", {21'h0, frame_num_o}, {21'h0, m_frn});
      do_wr(2'd1, 16'h0000, 32'h00C1, 0);
      chk("R3 no restart", {31'h0, start_o}, 0);
      do_wr(2'd1, 16'h0000, 32'h0080, 0);
      chk("R3 stop run", {31'h0, run_o}, 0);
      chk_reg("R3 stop halted", 2'd1, 5'h02);

      // R9 frame list base
      for (int k = 0; k < 6; k++) begin
         logic [31:0] d = 32'(k) * 32'h2468_ACE1 + 32'h0000_0FFF;
         do_wr(2'd2, 16'h0008, d, 0);
         chk("R9 aligned", frame_base_o, d & 32'hFFFF_F000);
         chk_reg("R9 readback", 2'd2, 5'h08);
      end

      // R10 start-of-frame timing
      for (int k = 0; k < 6; k++) begin
         do_wr(2'd0, 16'h000C, 32'(k * 47 + 3), 0);
         chk_reg("R10 sof", 2'd0, 5'h0C);
      end

      // R7 R6 R5 interrupt sweep: enable pattern x single event
      for (int en = 0; en < 16; en++) begin
         for (int e = 0; e < 6; e++) begin
            do_wr(2'd1, 16'h0004, 32'(en), 0);
            do_evt(6'(1 << e));
            chk("R7 irq after event", {31'h0, irq_o}, {31'h0, exp_irq()});
            chk_reg("R5 status after event", 2'd1, 5'h02);
            do_wr(2'd1, 16'h0002, 32'h3F, 0);
            chk("R7 irq after clear", {31'h0, irq_o}, {31'h0, exp_irq()});
         end
      end

      // R6 selective clear leaves cause bits until bit 0 written
      do_wr(2'd1, 16'h0004, 32'h000C, 0);
      do_evt(6'h02);
      do_wr(2'd1, 16'h0002, 32'h0002, 0);
      chk("R6 cause kept", {31'h0, irq_o}, 1);
      do_wr(2'd1, 16'h0002, 32'h0001, 0);
      chk("R6 cause cleared", {31'h0, irq_o}, 0);
      chk_reg("R6 status bit0", 2'd1, 5'h02);

      // R5 set wins over same-cycle clear
      do_wr(2'd1, 16'h0002, 32'h0008, 6'h10);
      chk_reg("R5 set wins", 2'd1, 5'h02);
      chk("R5 irq held", {31'h0, irq_o}, 1);
      do_wr(2'd1, 16'h0002, 32'h0001, 6'h01);
      chk("R5 cause set wins", {31'h0, irq_o}, 1);

      // R4 host reset with simultaneous events
      do_wr(2'd1, 16'h0000, 32'h0003, 6'h3F);
      chk("R4 host pulse", {30'h0, hc_rst_o, bus_rst_o}, 32'h2);
      chk("R4 irq cleared", {31'h0, irq_o}, 0);
      chk("R4 sof default", {24'h0, sof_o}, 32'd64);
      chk("R4 base zero", frame_base_o, 0);
      chk("R4 frame kept", {21'h0, frame_num_o}, {21'h0, m_frn});
      chk_reg("R4 status zero", 2'd1, 5'h02);
      chk_reg("R4 cmd zero", 2'd1, 5'h00);
      chk_reg("R4 enable zero", 2'd1, 5'h04);
      chk("R4 pulse ends", {30'h0, hc_rst_o, bus_rst_o}, 0);
      do_wr(2'd1, 16'h0000, 32'h0006, 0);
      chk("R4 bus pulse", {30'h0, hc_rst_o, bus_rst_o}, 32'h1);

      // R12 port write strobe
      @(negedge clk);
      acc_en = 1; acc_wr = 1; acc_size = 2'd1; acc_addr = 16'h0012; acc_wdata = 32'h1;
      #1;
      chk("R12 write strobe", {28'h0, port_sel_o, port_idx_o}, 32'h9);
      acc_addr = 16'h0016;
      #1;
      chk("R12 out of range", {31'h0, port_sel_o}, 0);
      acc_en = 0; acc_wr = 0;

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule